// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Unit

The block is a compact timer subsystem for a microcontroller-class core. Each pulse of `clk_i` is one instruction clock. The unit holds a prescaler with two division settings, four 8-bit reloadable down-counters and a free-running counter that nothing can stop or modify. Every down-counter picks its count pulses from a small per-channel source list. That list can be the previous channel's underflow, the prescaler tick, a synchronized rising edge on an external pin, or the wrap of the free-running counter. Chaining the channels gives division ratios far beyond 256.

Software configures the unit through a write-only register port. An underflow reloads the channel from its reload register and sets a sticky interrupt flag. An underflow can also toggle one of two pin outputs.

Top module: `chain_timer_unit`

## Requirements
- R1: After reset, `irq_o`, `pin0_o` and `pin1_o` are all 0, every channel is stopped, and the prescaler is disabled.
- R2: Address 0 sets the prescaler. Bit 0 enables it and bit 1 selects the ratio: 0 gives one tick every 4 clocks and 1 gives one tick every 16 clocks.
- R3: Address 5+k (k = 0..3) loads both the reload value and the count of channel k. A reload value of N-1 makes the channel underflow once every N selected pulses (N = 1..256), and on each underflow the count returns to the reload value.
- R4: Address 1+k holds the control of channel k: bit 0 is run and bits 2:1 are the source. For channel 0, source 0 is every clock and source 1 is the prescaler tick; sources 2 and 3 give no pulses.
- R5: Channel 1 sources are: 0 for channel 0 underflow, 1 for the prescaler tick, 2 for a rising edge on `ext0_i`, and 3 for the free-running counter wrap.
- R6: Channel 2 sources are: 0 for channel 1 underflow and 1 for the prescaler tick; sources 2 and 3 give nothing. Channel 3 sources are: 0 for channel 2 underflow, 1 for the prescaler tick, and 2 for a rising edge on `ext1_i`; source 3 gives nothing. A chained underflow counts in the same clock cycle.
- R7: While the run bit of a channel is 0, its count holds and it produces no underflow.
- R8: An underflow of channel k sets `irq_o[k]` on the next clock edge. The flag stays set until a write to address 9 with data bit k set. If an underflow and a clear arrive in the same cycle, the set wins.
- R9: Address 10 configures the pins. Bit 0 enables `pin0_o` and bit 1 picks its channel (0 selects channel 0, 1 selects channel 1). Bit 2 enables `pin1_o` and bit 3 picks its channel (0 selects channel 2, 1 selects channel 3). An enabled pin toggles on every underflow of its chosen channel.
- R10: The external inputs pass through a two-flop synchronizer. Each rising edge counts as exactly one pulse, and that pulse is taken at the third clock edge after the input rises.
- R11: The free-running counter increments on every clock and wraps every 2^FREE_W clocks. Its wrap pulse is unaffected by any register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ext0_i | input | 1 | External count input for channel 1 |
| ext1_i | input | 1 | External count input for channel 3 |
| irq_o | output | 4 | Sticky underflow flags, one per channel |
| pin0_o | output | 1 | Toggle output driven by channel 0 or 1 |
| pin1_o | output | 1 | Toggle output driven by channel 2 or 3 |

## Verification
The bench keeps the 8-bit channel width and the 4/16 prescaler ratios at their defaults. It shrinks FREE_W to 10, so the free-running wrap recurs every 1024 clocks. With that setting, channel 1 fed by the wrap can be seen underflowing several times inside a short run; at the full 16-bit width one wrap alone takes 65536 clocks. Toggle counts on the pins over windows that are whole multiples of the expected period give exact expected values for the clock, prescaler, chained and wrap sources.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR     = 4;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int ADR_PRE     = 0;
  localparam int ADR_CTRL0   = 1;
  localparam int ADR_RELOAD0 = 5;
  localparam int ADR_IRQ_CLR = 9;
  localparam int ADR_PIN     = 10;

  typedef enum logic [1:0] {
    SRC_CHAIN = 2'd0,
    SRC_PRE   = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_FREE  = 2'd3
  } src_e;

  typedef struct packed {
    src_e sel;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hi_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = hi_i ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // last synchronized stage against its delayed copy
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         uf_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] rld_q;
  logic [W-1:0] cnt_q;

  assign uf_o  = run_i && tick_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      rld_q <= load_val_i;
      cnt_q <= load_val_i;
    end else if (uf_o) begin
      cnt_q <= rld_q;
    end else if (run_i && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/chain_timer_unit.sv
module chain_timer_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FREE_W     = 16,
  parameter int PRE_DIV_LO = 4,
  parameter int PRE_DIV_HI = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                ext0_i,
  input  logic                ext1_i,
  output logic [NUM_TMR-1:0]  irq_o,
  output logic                pin0_o,
  output logic                pin1_o
);
  logic                          pre_en_q, pre_hi_q, pre_tick;
  logic [FREE_W-1:0]             free_cnt;
  logic                          free_uf;
  logic [1:0]                    ext_rise;
  logic [NUM_TMR-1:0]            uf;
  logic [NUM_TMR-1:0]            run_v;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v;
  logic [NUM_TMR-1:0]            irq_q;
  logic [NUM_TMR-1:0]            clr_mask;
  logic [3:0]                    pin_cfg_q;
  logic [1:0]                    pin_q;
  logic                          pin0_hit, pin1_hit;

  // prescaler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q <= 1'b0;
      pre_hi_q <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_W'(ADR_PRE)) begin
      pre_en_q <= wr_data_i[0];
      pre_hi_q <= wr_data_i[1];
    end
  end

  tmr_prescaler #(.DIV_LO(PRE_DIV_LO), .DIV_HI(PRE_DIV_HI)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pre_en_q),
    .hi_i   (pre_hi_q),
    .tick_o (pre_tick)
  );

  // free-running counter, no control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_cnt <= '0;
    else         free_cnt <= free_cnt + 1'b1;
  end
  assign free_uf = &free_cnt;

  tmr_edge_sync #(.STAGES(2)) u_sync0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ext0_i), .rise_o (ext_rise[0])
  );
  tmr_edge_sync #(.STAGES(2)) u_sync1 (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ext1_i), .rise_o (ext_rise[1])
  );

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    tmr_ctrl_t  ctrl_q;
    logic       chain_s, ext_s, free_s, tick;
    logic [3:0] srcs;
    logic       ctrl_wr, load_wr;

    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL0 + k));
    assign load_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADR_RELOAD0 + k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '{sel: SRC_CHAIN, run: 1'b0};
      else if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(wr_data_i[2:0]);
    end

    if (k == 0) begin : g_head
      assign chain_s = 1'b1;
    end else begin : g_link
      assign chain_s = uf[k-1];
    end

    if (k == 1) begin : g_src1
      assign ext_s  = ext_rise[0];
      assign free_s = free_uf;
    end else if (k == 3) begin : g_src3
      assign ext_s  = ext_rise[1];
      assign free_s = 1'b0;
    end else begin : g_srcn
      assign ext_s  = 1'b0;
      assign free_s = 1'b0;
    end

    assign srcs = {free_s, ext_s, pre_tick, chain_s};
    assign tick = srcs[ctrl_q.sel];

    tmr_down_cnt #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (ctrl_q.run),
      .tick_i     (tick),
      .load_i     (load_wr),
      .load_val_i (wr_data_i[CNT_W-1:0]),
      .uf_o       (uf[k]),
      .cnt_o      (cnt_v[k])
    );

    assign run_v[k] = ctrl_q.run;
  end

  // sticky flags, set beats clear
  assign clr_mask = (wr_en_i && wr_addr_i == ADDR_W'(ADR_IRQ_CLR)) ?
                    wr_data_i[NUM_TMR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= (irq_q & ~clr_mask) | uf;
  end
  assign irq_o = irq_q;

  // toggle pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         pin_cfg_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_W'(ADR_PIN))  pin_cfg_q <= wr_data_i[3:0];
  end

  assign pin0_hit = pin_cfg_q[0] && (pin_cfg_q[1] ? uf[1] : uf[0]);
  assign pin1_hit = pin_cfg_q[2] && (pin_cfg_q[3] ? uf[3] : uf[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_q ^ {pin1_hit, pin0_hit};
  end
  assign pin0_o = pin_q[0];
  assign pin1_o = pin_q[1];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FREE_W = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i,
  input logic [NUM_TMR-1:0]            uf,
  input logic [NUM_TMR-1:0]            run_v,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_TMR-1:0]            irq_o,
  input logic [3:0]                    pin_cfg_q,
  input logic                          pin0_o,
  input logic                          pin1_o,
  input logic [FREE_W-1:0]             free_cnt
);
  for (genvar k = 0; k < NUM_TMR; k++) begin : g_chk
    // R8
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] && !(wr_en_i && wr_addr_i == ADDR_W'(ADR_IRQ_CLR) && wr_data_i[k])
      |=> irq_o[k]);

    // R8
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[k]) |-> $past(uf[k]));

    // R7
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_v[k] && !(wr_en_i && wr_addr_i == ADDR_W'(ADR_RELOAD0 + k))
      |=> $stable(cnt_v[k]));
  end

  // R9
  pin0_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin0_o) |-> $past(pin_cfg_q[0] && (uf[0] || uf[1])));

  // R9
  pin1_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin1_o) |-> $past(pin_cfg_q[2] && (uf[2] || uf[3])));

  // R11
  free_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> free_cnt == FREE_W'($past(free_cnt) + 1'b1));
endmodule

bind chain_timer_unit tmr_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .uf        (uf),
  .run_v     (run_v),
  .cnt_v     (cnt_v),
  .irq_o     (irq_o),
  .pin_cfg_q (pin_cfg_q),
  .pin0_o    (pin0_o),
  .pin1_o    (pin1_o),
  .free_cnt  (free_cnt)
);

// File: tb/chain_timer_unit_tb_top.sv
`timescale 1ns/1ps
module chain_timer_unit_tb_top;
  localparam int FW  = 10;
  localparam int FMX = (1 << FW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext0 = 1'b0, ext1 = 1'b0;
  logic [3:0] irq;
  logic       pin0, pin1;

  int n_chk = 0, n_fail = 0;
  int tog0 = 0, tog1 = 0;
  logic prev0 = 1'b0, prev1 = 1'b0;

  always #2.5 clk = ~clk;

  chain_timer_unit #(.FREE_W(FW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .ext0_i (ext0), .ext1_i (ext1),
    .irq_o (irq), .pin0_o (pin0), .pin1_o (pin1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int  m_pcnt, m_pen, m_phi, m_free, m_pcfg;
  int  m_cnt[4], m_rld[4], m_run[4], m_sel[4], m_irq[4], m_pin[2];
  bit  m_a[3], m_b[3];
  bit  m_uf[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pcnt = 0; m_pen = 0; m_phi = 0; m_free = 0; m_pcfg = 0;
      for (int k = 0; k < 4; k++) begin
        m_cnt[k] = 0; m_rld[k] = 0; m_run[k] = 0; m_sel[k] = 0; m_irq[k] = 0;
      end
      m_pin[0] = 0; m_pin[1] = 0;
      for (int i = 0; i < 3; i++) begin m_a[i] = 0; m_b[i] = 0; end
    end else begin
      int lim; bit ptick, fuf, e0, e1, p;
      lim   = m_phi ? 15 : 3;
      ptick = (m_pen != 0) && (m_pcnt >= lim);
      m_pcnt = (m_pen == 0 || ptick) ? 0 : m_pcnt + 1;
      fuf   = (m_free == FMX);
      m_free = (m_free + 1) % (FMX + 1);
      e0 = m_a[1] && !m_a[2]; m_a[2] = m_a[1]; m_a[1] = m_a[0]; m_a[0] = ext0;
      e1 = m_b[1] && !m_b[2]; m_b[2] = m_b[1]; m_b[1] = m_b[0]; m_b[0] = ext1;
      for (int k = 0; k < 4; k++) begin
        case (m_sel[k])
          0: p = (k == 0) ? 1'b1 : m_uf[k-1];
          1: p = ptick;
          2: p = (k == 1) ? e0 : (k == 3) ? e1 : 1'b0;
          default: p = (k == 1) ? fuf : 1'b0;
        endcase
        m_uf[k] = (m_run[k] != 0) && p && (m_cnt[k] == 0);
        if (m_uf[k]) m_cnt[k] = m_rld[k];
        else if (m_run[k] != 0 && p) m_cnt[k] = m_cnt[k] - 1;
        if (m_uf[k]) m_irq[k] = 1;
      end
      if ((m_pcfg & 1) && m_uf[(m_pcfg >> 1) & 1]) m_pin[0] ^= 1;
      if ((m_pcfg & 4) && m_uf[2 + ((m_pcfg >> 3) & 1)]) m_pin[1] ^= 1;
      if (wr_en) begin
        if (wr_addr == 0) begin m_pen = wr_data[0]; m_phi = wr_data[1]; end
        else if (wr_addr >= 1 && wr_addr <= 4) begin
          m_run[wr_addr-1] = wr_data[0]; m_sel[wr_addr-1] = wr_data[2:1];
        end else if (wr_addr >= 5 && wr_addr <= 8) begin
          m_rld[wr_addr-5] = wr_data; m_cnt[wr_addr-5] = wr_data;
        end else if (wr_addr == 9) begin
          for (int k = 0; k < 4; k++) if (wr_data[k] && !m_uf[k]) m_irq[k] = 0;
        end else if (wr_addr == 10) m_pcfg = wr_data[3:0];
      end
    end
  end

  // per-cycle comparison and toggle counting
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++)
        chk(irq[k] == m_irq[k][0], "R8 irq flag vs model", irq[k], m_irq[k]);
      chk(pin0 == m_pin[0][0], "R9 pin0 vs model", pin0, m_pin[0]);
      chk(pin1 == m_pin[1][0], "R9 pin1 vs model", pin1, m_pin[1]);
      if (pin0 != prev0) tog0++;
      if (pin1 != prev1) tog1++;
      prev0 = pin0; prev1 = pin1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int t0, output int t1);
    int a, b;
    a = tog0; b = tog1;
    idle(n);
    t0 = tog0 - a; t1 = tog1 - b;
  endtask

  task automatic pulse0();
    @(negedge clk); ext0 = 1'b1; idle(4); ext0 = 1'b0; idle(4);
  endtask

  bit done = 0;

  initial begin
    int t0, t1;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    // R1
    chk(irq == 4'h0, "R1 irq after reset", irq, 0);
    chk(pin0 == 1'b0 && pin1 == 1'b0, "R1 pins after reset", {pin1, pin0}, 0);

    // R3: channel 0 on clock, N=7
    wr(10, 4'h5); wr(5, 6); wr(1, 8'h01);
    idle(30); measure(70, t0, t1);
    chk(t0 == 10, "R3 ch0 period 7 toggles", t0, 10);
    chk(irq[0] == 1'b1, "R8 flag sticky after underflow", irq[0], 1);

    // R7: stopped channel
    wr(1, 8'h00); idle(5); measure(50, t0, t1);
    chk(t0 == 0, "R7 stopped channel no toggles", t0, 0);
    wr(9, 4'hF); idle(3);
    chk(irq[0] == 1'b0, "R8 flag cleared by write", irq[0], 0);

    // R2: prescaler ratios
    wr(0, 8'h01); wr(5, 0); wr(1, 8'h03);
    idle(30); measure(160, t0, t1);
    chk(t0 == 40, "R2 prescaler div4 toggles", t0, 40);
    wr(0, 8'h03); idle(40); measure(160, t0, t1);
    chk(t0 == 10, "R2 prescaler div16 toggles", t0, 10);

    // R4: unused source slot
    wr(1, 8'h05); idle(5); wr(9, 4'hF); measure(50, t0, t1);
    chk(t0 == 0, "R4 ch0 source 2 gives no pulses", t0, 0);
    chk(irq[0] == 1'b0, "R4 ch0 source 2 no flag", irq[0], 0);

    // R6: chain 0 -> 1 -> 2 -> 3
    wr(5, 1); wr(1, 8'h01); wr(6, 2); wr(2, 8'h01); wr(7, 3); wr(3, 8'h01);
    idle(60); measure(240, t0, t1);
    chk(t1 == 10, "R6 ch2 chained period 24", t1, 10);
    chk(t0 == 120, "R3 ch0 period 2 toggles", t0, 120);
    wr(10, 4'hD); wr(8, 0); wr(4, 8'h01);
    idle(60); measure(240, t0, t1);
    chk(t1 == 10, "R6 ch3 chained on ch2", t1, 10);

    // R5 / R10: external pin source
    wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);
    wr(6, 2); wr(2, 8'h05); wr(9, 4'hF); idle(3);
    pulse0(); pulse0(); idle(6);
    chk(irq[1] == 1'b0, "R10 two edges no underflow", irq[1], 0);
    pulse0(); idle(6);
    chk(irq[1] == 1'b1, "R5 third ext0 edge underflows", irq[1], 1);
    // R6: ext1 into ch3
    wr(8, 0); wr(4, 8'h05); wr(9, 4'hF); idle(3);
    chk(irq[3] == 1'b0, "R6 ch3 idle before ext1", irq[3], 0);
    @(negedge clk); ext1 = 1'b1; idle(6);
    chk(irq[3] == 1'b1, "R6 ext1 edge underflows ch3", irq[3], 1);
    ext1 = 1'b0;

    // R11: free-running wrap into ch1
    wr(4, 0); wr(10, 4'h3); wr(6, 1); wr(2, 8'h07);
    idle(100); measure(4096, t0, t1);
    chk(t0 == 2, "R11 wrap-fed ch1 toggles", t0, 2);
    chk(irq[1] == 1'b1, "R5 ch1 flag from free source", irq[1], 1);

    idle(5);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule